// File: doc/BRIEF.md
# Bus Cycle Status and Bank Multiplexer

This block sits at the pin edge of a CPU that has an 8-bit external data bus and 24-bit addressing. For every bus cycle the sequencer supplies a cycle kind: internal, program read, data access, opcode fetch or vector read. From it the block drives two status lines that tell memory and cache logic what the address bus carries. It also drives an active-low vector strobe, which marks the cycles that read an interrupt vector.

Each bus cycle takes two ticks of `clk`. `half2` is 0 on the tick that opens a cycle and 1 on the tick that closes it. The block captures the cycle kind, the bank byte, the write data and the write request on the opening tick. It holds them for the whole cycle.

The data lines are shared. In the first half of every memory cycle they carry the bank byte, so that external logic can latch the upper address bits. In the second half they carry the write data on a data write and are released on any read. The tri-state control is brought out as a separate enable next to the bus value.

Top module: `bus_cycle_mux`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first cycle is opened, `vda`=0, `vpa`=0, `vp_n`=1, `bus_oe`=0 and `bus_out`=0.
- R2: The cycle kind codes on `cyc_kind` and their status pairs (`vda`,`vpa`) are:
  - 0, internal: (0,0)
  - 1, program read: (0,1)
  - 2, data access: (1,0)
  - 3, opcode fetch: (1,1)
  - 4, vector read: (1,0)
  - 5, 6 and 7 are treated as internal: (0,0)
- R3: `vp_n` is 0 for both halves of a cycle opened with code 4 and is 1 in all other cycles. An interrupt sequence asserts it for its two final cycles by issuing code 4 twice.
- R4: The status outputs take new values only on a tick with `half2`=0. On a tick with `half2`=1 they stay unchanged, whatever the inputs do.
- R5: In the first half of a memory cycle (codes 1 to 4), `bus_oe`=1 and `bus_out` equals the bank byte captured when the cycle was opened.
- R6: In the second half of a code 2 cycle opened with `wr_en`=1, `bus_oe`=1 and `bus_out` equals the write data captured when the cycle was opened.
- R7: In the second half of any other memory cycle, `bus_oe`=0. `wr_en` has no effect on codes 1, 3 and 4.
- R8: In an internal cycle (codes 0, 5, 6 and 7), `bus_oe`=0 in both halves.
- R9: `bus_out` is 0 whenever `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half2 | input | 1 | 0 on the tick that opens a bus cycle, 1 on the tick that closes it |
| cyc_kind | input | 3 | Cycle kind code for the cycle being opened |
| bank | input | 8 | Bank byte for the cycle being opened |
| wdata | input | 8 | Write data for the cycle being opened |
| wr_en | input | 1 | Write request, honoured on data access cycles only |
| bus_out | output | 8 | Value driven on the shared data/bank lines |
| bus_oe | output | 1 | Output enable for the shared lines (1 = drive) |
| vda | output | 1 | Data address valid status |
| vpa | output | 1 | Program address valid status |
| vp_n | output | 1 | Vector read strobe, active low |

## Verification
A wrong captured cycle kind shows up one tick after the opening edge. It appears as a wrong status pair or vector strobe, and it stays wrong for both halves of the cycle. A stale or dropped write flag appears only at the closing tick: a read drives the bus, or a write leaves it released. A bad phase register swaps bank and data between the two halves. It is visible on the first memory cycle after the fault.

// File: rtl/bus_cycle_mux.sv
module bus_cycle_mux #(
  parameter int DW = 8,
  parameter int BW = 8,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half2,
  input  logic [KW-1:0] cyc_kind,
  input  logic [BW-1:0] bank,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          vda,
  output logic          vpa,
  output logic          vp_n
);
  localparam logic [KW-1:0] K_PROG = KW'(1);
  localparam logic [KW-1:0] K_DATA = KW'(2);
  localparam logic [KW-1:0] K_OPF  = KW'(3);
  localparam logic [KW-1:0] K_VEC  = KW'(4);

  logic          d_vda, d_vpa, d_vec;
  logic          vda_q, vpa_q, vec_q, wr_q, ph_q;
  logic [BW-1:0] bank_q;
  logic [DW-1:0] wd_q;

  always_comb begin
    d_vda = 1'b0;
    d_vpa = 1'b0;
    d_vec = 1'b0;
    case (cyc_kind)
      K_PROG: d_vpa = 1'b1;
      K_DATA: d_vda = 1'b1;
      K_OPF: begin
        d_vda = 1'b1;
        d_vpa = 1'b1;
      end
      K_VEC: begin
        d_vda = 1'b1;
        d_vec = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      vda_q  <= 1'b0;
      vpa_q  <= 1'b0;
      vec_q  <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= '0;
      wd_q   <= '0;
    end else begin
      ph_q <= half2;
      if (!half2) begin
        vda_q  <= d_vda;
        vpa_q  <= d_vpa;
        vec_q  <= d_vec;
        wr_q   <= wr_en && (cyc_kind == K_DATA);
        bank_q <= bank;
        wd_q   <= wdata;
      end
    end
  end

  wire mem_q = vda_q | vpa_q;

  assign vda     = vda_q;
  assign vpa     = vpa_q;
  assign vp_n    = ~vec_q;
  assign bus_oe  = mem_q & (~ph_q | wr_q);
  assign bus_out = !bus_oe ? '0 : (ph_q ? wd_q : DW'(bank_q));
endmodule

module bus_cycle_mux_chk #(
  parameter int DW = 8,
  parameter int BW = 8,
  parameter int KW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half2,
  input logic [KW-1:0] cyc_kind,
  input logic [BW-1:0] bank,
  input logic [DW-1:0] bus_out,
  input logic          bus_oe,
  input logic          vda,
  input logic          vpa,
  input logic          vp_n
);
  AST_VEC_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n) !vp_n |-> (vda && !vpa)); // R3
  AST_HOLD_STATUS: assert property (@(posedge clk) disable iff (!rst_n) half2 |=> ($stable(vda) && $stable(vpa) && $stable(vp_n))); // R4
  AST_BANK_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (!half2 && cyc_kind >= KW'(1) && cyc_kind <= KW'(4)) |=> (bus_oe && bus_out == DW'($past(bank)))); // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (half2 && vpa) |=> !bus_oe); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!vda && !vpa) |-> !bus_oe); // R8
  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n) !bus_oe |-> (bus_out == '0)); // R9
endmodule

bind bus_cycle_mux bus_cycle_mux_chk #(.DW(DW), .BW(BW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .half2(half2), .cyc_kind(cyc_kind), .bank(bank),
  .bus_out(bus_out), .bus_oe(bus_oe), .vda(vda), .vpa(vpa), .vp_n(vp_n)
);

// File: tb/bus_cycle_mux_tb.sv
module bus_cycle_mux_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half2 = 1'b0;
  logic [2:0] cyc_kind = 3'd0;
  logic [7:0] bank = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] bus_out;
  logic       bus_oe, vda, vpa, vp_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic       vda, vpa, vp_n, oe;
    logic [7:0] dout;
    string      bus_req;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_mux u_dut (
    .clk(clk), .rst_n(rst_n), .half2(half2), .cyc_kind(cyc_kind), .bank(bank),
    .wdata(wdata), .wr_en(wr_en), .bus_out(bus_out), .bus_oe(bus_oe),
    .vda(vda), .vpa(vpa), .vp_n(vp_n)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R2 / R3 model: expected status for a cycle kind
  function automatic exp_t model(input logic [2:0] k, input bit second, input logic [7:0] b,
                                 input logic [7:0] w, input logic we);
    exp_t e;
    logic mem, wr;
    e.vda  = (k == 3'd2) || (k == 3'd3) || (k == 3'd4);
    e.vpa  = (k == 3'd1) || (k == 3'd3);
    e.vp_n = !(k == 3'd4);
    mem    = e.vda || e.vpa;
    wr     = we && (k == 3'd2);
    if (!second) begin
      e.oe = mem;
      e.dout = mem ? b : 8'h00;
      e.bus_req = mem ? "R5" : "R8";
    end else begin
      e.oe = wr;
      e.dout = wr ? w : 8'h00;
      e.bus_req = !mem ? "R8" : (wr ? "R6" : "R7");
    end
    return e;
  endfunction

  task automatic bus_cycle(input logic [2:0] k, input logic [7:0] b, input logic [7:0] w, input logic we);
    @(negedge clk);
    half2 = 1'b0; cyc_kind = k; bank = b; wdata = w; wr_en = we;
    q.push_back(model(k, 1'b0, b, w, we));
    @(negedge clk);
    // inputs change in the second half: must be ignored (R4)
    half2 = 1'b1; cyc_kind = k ^ 3'd5; bank = ~b; wdata = ~w; wr_en = ~we;
    q.push_back(model(k, 1'b1, b, w, we));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R2/R4", "vda", {7'd0, vda}, {7'd0, e.vda});
        chk("R2/R4", "vpa", {7'd0, vpa}, {7'd0, e.vpa});
        chk("R3", "vp_n", {7'd0, vp_n}, {7'd0, e.vp_n});
        chk(e.bus_req, "bus_oe", {7'd0, bus_oe}, {7'd0, e.oe});
        chk(e.oe ? e.bus_req : "R9", "bus_out", bus_out, e.dout);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "vda", {7'd0, vda}, 8'h00);
    chk("R1", "vpa", {7'd0, vpa}, 8'h00);
    chk("R1", "vp_n", {7'd0, vp_n}, 8'h01);
    chk("R1", "bus_oe", {7'd0, bus_oe}, 8'h00);
    chk("R1", "bus_out", bus_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "bus_oe after release", {7'd0, bus_oe}, 8'h00);

    // R2: every code, read and write request
    for (int k = 0; k < 8; k++) begin
      bus_cycle(3'(k), 8'h10 + 8'(k), 8'hA0 + 8'(k), 1'b0);
      bus_cycle(3'(k), 8'h20 + 8'(k), 8'hB0 + 8'(k), 1'b1); // R7: wr_en only on code 2
    end

    // R3: interrupt-like sequence ending in two vector reads
    bus_cycle(3'd3, 8'h01, 8'h00, 1'b0);
    bus_cycle(3'd0, 8'h01, 8'h00, 1'b0);
    bus_cycle(3'd2, 8'h00, 8'h12, 1'b1);
    bus_cycle(3'd2, 8'h00, 8'h34, 1'b1);
    bus_cycle(3'd2, 8'h00, 8'h56, 1'b1);
    bus_cycle(3'd4, 8'h00, 8'h00, 1'b0);
    bus_cycle(3'd4, 8'h00, 8'h00, 1'b1);
    bus_cycle(3'd3, 8'h02, 8'h00, 1'b0);

    // R5/R6 boundary data values
    bus_cycle(3'd2, 8'hFF, 8'h00, 1'b1);
    bus_cycle(3'd2, 8'h00, 8'hFF, 1'b1);

    // mixed traffic
    for (int i = 0; i < 300; i++)
      bus_cycle(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 1'($urandom));

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule